// File: doc/BRIEF.md
# Multidrop Asynchronous Serial Port

This core is the asynchronous serial port of a small microcontroller. It sends and receives frames that carry one start bit, eight data bits sent least significant bit first, an optional ninth bit and one stop bit. The receiver oversamples the line sixteen times per bit and decides each bit by a majority vote near the bit centre. Software reaches the core through a two-register port. The control register (address 0) holds the mode, the enables, the ninth bits and the two interrupt flags. The data register (address 1) starts a transmission when it is written and returns the last accepted byte when it is read.

In a multidrop network, one master addresses many listeners. Each listener can hide incoming frames from software until one of them carries its own address or the broadcast address. The address filter uses the ninth bit as an "address frame" marker in the 9-bit modes and the stop bit in the 8-bit mode. A framing error is recorded in a sticky flag. That flag shares bit 7 of the control register with the upper mode bit, and an external select input chooses which of the two bit 7 reaches.

Top module: `mpu_uart`

## Requirements
- R1: After reset, the control register reads 0x00 with either value of the bit-7 select, the data register reads 0x00, `txd` is 1, and `ti` and `ri` are 0.
- R2: Control bits 7:6 hold the mode {hi,lo}. Mode 00 is inert: a data-register write sends nothing, `txd` stays 1 and `ti` stays 0.
- R3: In mode 01, a data-register write sends a 10-bit frame: a 0 start bit, then data bits 0 to 7, then a 1 stop bit. Each bit lasts 16 `baud16_tick` pulses.
- R4: In modes 10 and 11, the frame holds 11 bits, and the bit after data bit 7 is control bit 3 (the transmit ninth bit).
- R5: Control bit 1 (`ti`) is set when the transmitted stop bit begins. It stays 1 until software writes a 0 to it.
- R6: In mode 01 with control bit 5 (filter enable) at 0, each received frame sets control bit 0 (`ri`) halfway through the stop bit. It loads the byte into the data register and copies the received stop bit into control bit 2.
- R7: A stop bit that samples as 0 sets a sticky framing flag, and a later good frame does not clear it. With `fe_sel`=1, control bit 7 reads and writes the flag and leaves the mode bit unchanged. With `fe_sel`=0, bit 7 reads and writes the mode bit.
- R8: While control bit 4 (receive enable) is 0, incoming frames change neither `ri` nor the data register.
- R9: In the 9-bit modes with the filter enabled, a frame is accepted only if its ninth bit is 1 and its byte matches the own or the broadcast address. A rejected frame leaves `ri` and the data register unchanged.
- R10: In mode 01 with the filter enabled, a frame is accepted only if its stop bit is 1 and its byte matches an address.
- R11: A byte matches an address when it equals that address in every bit position where the address's mask is 1.
- R12: A start bit counts only if samples 7, 8 and 9 of the bit vote low. A shorter low pulse is dropped, and the receiver stays ready for the next frame.
- R13: Mode 10 ignores `baud16_tick`. Each bit lasts 16*DIV_FAST clocks when `div_fast`=1, and 16*DIV_SLOW clocks when `div_fast`=0.
- R14: If hardware sets `ti` or `ri` in the same cycle as a software write of the control register, the hardware set wins over the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, also the oscillator for mode 10 |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 1 | 0 = control register, 1 = data register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data for `bus_addr` |
| fe_sel | input | 1 | Selects what control bit 7 reaches: 0 = mode bit, 1 = framing flag |
| baud16_tick | input | 1 | One-cycle pulse at 16 times the bit rate, used in modes 01 and 11 |
| div_fast | input | 1 | Mode 10 bit-rate select |
| own_addr | input | 8 | Own address for the filter |
| own_mask | input | 8 | Bits of `own_addr` that must match |
| bcast_addr | input | 8 | Broadcast address |
| bcast_mask | input | 8 | Bits of `bcast_addr` that must match |
| rxd | input | 1 | Serial input |
| txd | output | 1 | Serial output |
| ti | output | 1 | Transmit flag |
| ri | output | 1 | Receive flag |

## Verification
A receive completion can land in the same cycle as a software write that clears `ri`. These two events collide when the driver polls the control register and clears the flag at exactly that point. To provoke the collision, the bench feeds a frame into `rxd` while it writes 0x50 to the control register on every cycle of the frame. Under set-wins, `ri` must read high for exactly one cycle, and the data register must still hold the new byte. If the clear wins instead, `ri` never rises, and the bench reports the loss.

// File: rtl/mpu_pkg.sv
package mpu_pkg;
  typedef enum logic [1:0] {
    MD_SHIFT  = 2'b00,
    MD_UART8  = 2'b01,
    MD_UART9F = 2'b10,
    MD_UART9V = 2'b11
  } mpu_mode_e;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_NINTH,
    RX_STOP
  } rx_st_e;

  localparam int OVS = 16;
endpackage

// File: rtl/mpu_tick_sel.sv
module mpu_tick_sel
  import mpu_pkg::*;
#(
  parameter int DIV_SLOW = 4,
  parameter int DIV_FAST = 2
) (
  input  logic      clk,
  input  logic      rst,
  input  mpu_mode_e mode,
  input  logic      fast_sel,
  input  logic      ext_tick,
  output logic      tick
);
  localparam int CW = $clog2(DIV_SLOW + DIV_FAST);

  logic [CW-1:0] cnt;
  logic [CW-1:0] lim;

  assign lim = fast_sel ? CW'(DIV_FAST - 1) : CW'(DIV_SLOW - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else begin
      case (mode)
        MD_UART8, MD_UART9V: begin
          cnt  <= '0;
          tick <= ext_tick;
        end
        MD_UART9F: begin
          if (cnt >= lim) begin
            cnt  <= '0;
            tick <= 1'b1;
          end else begin
            cnt  <= cnt + CW'(1);
            tick <= 1'b0;
          end
        end
        default: begin
          cnt  <= '0;
          tick <= 1'b0;
        end
      endcase
    end
  end

  // R2
  shift_no_tick_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == MD_SHIFT) |=> (!tick || $past(mode) != MD_SHIFT));
endmodule

// File: rtl/mpu_tx.sv
module mpu_tx #(
  parameter int DW  = 8,
  parameter int OVS = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          load,
  input  logic          nine,
  input  logic          bit9,
  input  logic [DW-1:0] data,
  output logic          txd,
  output logic          busy,
  output logic          stop_start
);
  localparam int FW = DW + 3;
  localparam int BW = $clog2(FW + 1);
  localparam int PW = $clog2(OVS);

  logic [FW-1:0] sh;
  logic [BW-1:0] bidx;
  logic [BW-1:0] bnext;
  logic [BW-1:0] last;
  logic [PW-1:0] ph;
  logic          nine_q;

  assign last  = nine_q ? BW'(DW + 2) : BW'(DW + 1);
  assign bnext = bidx + BW'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      txd        <= 1'b1;
      busy       <= 1'b0;
      stop_start <= 1'b0;
      sh         <= '1;
      bidx       <= '0;
      ph         <= '0;
      nine_q     <= 1'b0;
    end else begin
      stop_start <= 1'b0;
      if (!busy) begin
        if (load) begin
          busy   <= 1'b1;
          txd    <= 1'b0;
          sh     <= {1'b1, 1'b1, (nine ? bit9 : 1'b1), data};
          bidx   <= '0;
          ph     <= '0;
          nine_q <= nine;
        end
      end else if (tick) begin
        if (ph == PW'(OVS - 1)) begin
          ph <= '0;
          if (bidx == last) begin
            busy <= 1'b0;
            txd  <= 1'b1;
          end else begin
            bidx       <= bnext;
            txd        <= sh[0];
            sh         <= {1'b1, sh[FW-1:1]};
            stop_start <= (bnext == last);
          end
        end else begin
          ph <= ph + PW'(1);
        end
      end
    end
  end

  // R5
  stop_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    stop_start |=> !stop_start);

  // R3
  stop_level_chk: assert property (@(posedge clk) disable iff (rst)
    stop_start |-> (txd && busy));
endmodule

// File: rtl/mpu_rx.sv
module mpu_rx
  import mpu_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          en,
  input  logic          nine,
  input  logic          rxd_s,
  output logic          done,
  output logic [DW-1:0] dbyte,
  output logic          bit9,
  output logic          stop_ok
);
  localparam int PW = $clog2(OVS);
  localparam int CW = $clog2(DW);

  rx_st_e        st;
  logic [PW-1:0] ph;
  logic [CW-1:0] cnt;
  logic [1:0]    v;
  logic [DW-1:0] sh;
  logic          b9;
  logic          maj;

  always_comb maj = (v[1] & v[0]) | (v[1] & rxd_s) | (v[0] & rxd_s);

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= RX_IDLE;
      ph      <= '0;
      cnt     <= '0;
      v       <= '0;
      sh      <= '0;
      b9      <= 1'b0;
      done    <= 1'b0;
      dbyte   <= '0;
      bit9    <= 1'b0;
      stop_ok <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!en) begin
        st <= RX_IDLE;
      end else if (tick) begin
        if (st == RX_IDLE) begin
          if (!rxd_s) begin
            st <= RX_START;
            ph <= PW'(1);
          end
        end else begin
          if (ph == PW'(7) || ph == PW'(8)) v <= {v[0], rxd_s};
          if (ph == PW'(9)) begin
            case (st)
              RX_START: if (maj) st <= RX_IDLE;
              RX_DATA:  sh <= {maj, sh[DW-1:1]};
              RX_NINTH: b9 <= maj;
              RX_STOP: begin
                done    <= 1'b1;
                stop_ok <= maj;
                dbyte   <= sh;
                bit9    <= b9;
                st      <= RX_IDLE;
              end
              default: ;
            endcase
          end
          if (ph == PW'(OVS - 1)) begin
            ph <= '0;
            case (st)
              RX_START: begin
                st  <= RX_DATA;
                cnt <= '0;
              end
              RX_DATA: begin
                if (cnt == CW'(DW - 1)) st <= nine ? RX_NINTH : RX_STOP;
                else cnt <= cnt + CW'(1);
              end
              RX_NINTH: st <= RX_STOP;
              default: ;
            endcase
          end else begin
            ph <= ph + PW'(1);
          end
        end
      end
    end
  end

  // R12
  false_start_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && st == RX_START && ph == PW'(9) && maj) |=> (st == RX_IDLE));

  // R8
  rx_off_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> (st == RX_IDLE && !done));
endmodule

// File: rtl/mpu_addr_match.sv
module mpu_addr_match #(
  parameter int AW = 8,
  parameter int NA = 2
) (
  input  logic [AW-1:0]         rx_byte,
  input  logic [NA-1:0][AW-1:0] addrs,
  input  logic [NA-1:0][AW-1:0] masks,
  output logic                  hit
);
  logic [NA-1:0] each;

  generate
    for (genvar i = 0; i < NA; i++) begin : g_cmp
      assign each[i] = (((rx_byte ^ addrs[i]) & masks[i]) == '0);
    end
  endgenerate

  assign hit = |each;
endmodule

// File: rtl/mpu_uart.sv
module mpu_uart
  import mpu_pkg::*;
#(
  parameter int DW       = 8,
  parameter int DIV_SLOW = 4,
  parameter int DIV_FAST = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_wr,
  input  logic          bus_addr,
  input  logic [7:0]    bus_wdata,
  output logic [7:0]    bus_rdata,
  input  logic          fe_sel,
  input  logic          baud16_tick,
  input  logic          div_fast,
  input  logic [DW-1:0] own_addr,
  input  logic [DW-1:0] own_mask,
  input  logic [DW-1:0] bcast_addr,
  input  logic [DW-1:0] bcast_mask,
  input  logic          rxd,
  output logic          txd,
  output logic          ti,
  output logic          ri
);
  logic sm0, sm1, sm2, ren, tb8, rb8, ti_q, ri_q, fe_q;
  logic [DW-1:0] rxbuf;
  logic [1:0]    rxd_sync;
  mpu_mode_e     mode;
  logic          nine, uart_on, tick;
  logic          tx_busy, tx_stop, tx_load;
  logic          rx_done, rx_b9, rx_stop, rx_en;
  logic [DW-1:0] rx_byte;
  logic          hit, accept, rb8_new, ctrl_wr;

  assign mode    = mpu_mode_e'({sm0, sm1});
  assign nine    = sm0;
  assign uart_on = (mode != MD_SHIFT);
  assign ctrl_wr = bus_wr && !bus_addr;
  assign tx_load = bus_wr && bus_addr && uart_on && !tx_busy;
  assign rx_en   = ren && uart_on;

  always_ff @(posedge clk) begin
    if (rst) rxd_sync <= 2'b11;
    else     rxd_sync <= {rxd_sync[0], rxd};
  end

  mpu_tick_sel #(.DIV_SLOW(DIV_SLOW), .DIV_FAST(DIV_FAST)) u_tick (
    .clk(clk), .rst(rst), .mode(mode), .fast_sel(div_fast),
    .ext_tick(baud16_tick), .tick(tick)
  );

  mpu_tx #(.DW(DW), .OVS(OVS)) u_tx (
    .clk(clk), .rst(rst), .tick(tick), .load(tx_load), .nine(nine),
    .bit9(tb8), .data(bus_wdata[DW-1:0]), .txd(txd), .busy(tx_busy),
    .stop_start(tx_stop)
  );

  mpu_rx #(.DW(DW)) u_rx (
    .clk(clk), .rst(rst), .tick(tick), .en(rx_en), .nine(nine),
    .rxd_s(rxd_sync[1]), .done(rx_done), .dbyte(rx_byte),
    .bit9(rx_b9), .stop_ok(rx_stop)
  );

  mpu_addr_match #(.AW(DW), .NA(2)) u_match (
    .rx_byte(rx_byte),
    .addrs({bcast_addr, own_addr}),
    .masks({bcast_mask, own_mask}),
    .hit(hit)
  );

  always_comb begin
    rb8_new = nine ? rx_b9 : rx_stop;
    if (!sm2)      accept = 1'b1;
    else if (nine) accept = rx_b9 && hit;
    else           accept = rx_stop && hit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      {sm0, sm1, sm2, ren, tb8, rb8, ti_q, ri_q} <= '0;
      fe_q      <= 1'b0;
      rxbuf     <= '0;
      bus_rdata <= '0;
    end else begin
      if (ctrl_wr) begin
        if (fe_sel) fe_q <= bus_wdata[7];
        else        sm0  <= bus_wdata[7];
        {sm1, sm2, ren, tb8, rb8, ti_q, ri_q} <= bus_wdata[6:0];
      end
      if (rx_done) begin
        if (!rx_stop) fe_q <= 1'b1;
        if (accept) begin
          ri_q  <= 1'b1;
          rb8   <= rb8_new;
          rxbuf <= rx_byte;
        end
      end
      if (tx_stop) ti_q <= 1'b1;
      bus_rdata <= bus_addr ? 8'(rxbuf)
                            : {(fe_sel ? fe_q : sm0), sm1, sm2, ren, tb8, rb8, ti_q, ri_q};
    end
  end

  assign ti = ti_q;
  assign ri = ri_q;

  // R7
  fe_set_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_done && !rx_stop) |=> fe_q);

  // R7
  fe_hold_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(fe_q) |-> $past(ctrl_wr && fe_sel && !bus_wdata[7]));

  // R6
  ri_src_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ri_q) |-> $past(rx_done || (ctrl_wr && bus_wdata[0])));

  // R14
  ti_set_chk: assert property (@(posedge clk) disable iff (rst)
    tx_stop |=> ti_q);

  // R2
  shift_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == MD_SHIFT && !tx_busy) |=> !tx_busy);

  // R9
  filt9_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_done && sm2 && nine && !rx_b9 && !ri_q && !ctrl_wr) |=> !ri_q);
endmodule

// File: tb/sim_mpu_uart.sv
`timescale 1ns/1ps
module sim_mpu_uart;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_wr = 1'b0;
  logic       bus_addr = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       fe_sel = 1'b0;
  logic       baud16_tick = 1'b0;
  logic       div_fast = 1'b0;
  logic [7:0] own_addr = 8'h42, own_mask = 8'hFF;
  logic [7:0] bcast_addr = 8'hFF, bcast_mask = 8'hFF;
  logic       rxd = 1'b1;
  logic       txd, ti, ri;

  int n_chk = 0;
  int n_fail = 0;
  int tx_seen = 0;
  int tdiv = 0;

  typedef struct packed {
    logic [7:0] data;
    logic       nine;
    logic       b9;
    logic [7:0] bitclk;
  } tx_item_t;

  tx_item_t sbq[$];
  string    reqq[$];

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    if (tdiv == 3) begin tdiv <= 0; baud16_tick <= 1'b1; end
    else begin tdiv <= tdiv + 1; baud16_tick <= 1'b0; end
  end

  mpu_uart u0 (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .fe_sel(fe_sel),
    .baud16_tick(baud16_tick), .div_fast(div_fast),
    .own_addr(own_addr), .own_mask(own_mask),
    .bcast_addr(bcast_addr), .bcast_mask(bcast_mask),
    .rxd(rxd), .txd(txd), .ti(ti), .ri(ri)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic reg_write(input logic a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic reg_read(input logic a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic rx_frame(input logic [7:0] b, input bit nine, input bit b9,
                          input bit stp, input int bc);
    @(negedge clk);
    rxd = 1'b0;
    repeat (bc) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxd = b[i];
      repeat (bc) @(negedge clk);
    end
    if (nine) begin
      rxd = b9;
      repeat (bc) @(negedge clk);
    end
    rxd = stp;
    repeat (bc) @(negedge clk);
    rxd = 1'b1;
    repeat (2 * bc) @(negedge clk);
  endtask

  // driver: pushes the expected frame, then starts it
  task automatic tx_send(input logic [7:0] d, input bit nine, input bit b9,
                         input int bc, input string req);
    int k;
    tx_item_t it;
    k = tx_seen;
    it.data = d; it.nine = nine; it.b9 = b9; it.bitclk = 8'(bc);
    sbq.push_back(it);
    reqq.push_back(req);
    reg_write(1'b1, d);
    wait (tx_seen > k);
    repeat (bc) @(negedge clk);
  endtask

  // monitor: decodes txd and compares against the queue
  initial begin
    tx_item_t   it;
    string      rq;
    logic [10:0] got, exp;
    int         nb;
    forever begin
      @(negedge clk);
      if (txd === 1'b0 && sbq.size() > 0) begin
        it = sbq.pop_front();
        rq = reqq.pop_front();
        nb = it.nine ? 11 : 10;
        got = '1;
        repeat (int'(it.bitclk) / 2) @(negedge clk);
        got[0] = txd;
        for (int i = 1; i < nb; i++) begin
          repeat (int'(it.bitclk)) @(negedge clk);
          got[i] = txd;
        end
        exp = it.nine ? {1'b1, it.b9, it.data, 1'b0} : {1'b1, 1'b1, it.data, 1'b0};
        chk(got == exp, rq, int'(got), int'(exp));
        tx_seen++;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_up();
  end

  initial begin
    logic [7:0] v;
    int lows;
    bit seen;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    reg_read(1'b0, v); chk(v == 8'h00, "R1 ctrl", v, 8'h00);
    fe_sel = 1'b1;
    reg_read(1'b0, v); chk(v == 8'h00, "R1 ctrl fe view", v, 8'h00);
    fe_sel = 1'b0;
    reg_read(1'b1, v); chk(v == 8'h00, "R1 data", v, 8'h00);
    chk({txd, ti, ri} == 3'b100, "R1 pins", {txd, ti, ri}, 3'b100);

    // R2 mode 00 inert
    reg_write(1'b0, 8'h00);
    reg_write(1'b1, 8'h55);
    lows = 0;
    repeat (300) begin @(negedge clk); if (!txd) lows++; end
    chk(lows == 0 && !ti, "R2 mode00 tx", lows, 0);

    // R3 / R5 mode 01 transmit
    reg_write(1'b0, 8'h50);
    tx_send(8'hA5, 1'b0, 1'b0, 64, "R3 8-bit frame");
    chk(ti == 1'b1, "R5 ti after tx", ti, 1);
    reg_write(1'b0, 8'h50);
    chk(ti == 1'b0, "R5 ti cleared", ti, 0);

    // R4 mode 11 ninth bit
    reg_write(1'b0, 8'hD8);
    tx_send(8'h3C, 1'b1, 1'b1, 64, "R4 tb8=1 frame");
    reg_write(1'b0, 8'hD0);
    tx_send(8'hC3, 1'b1, 1'b0, 64, "R4 tb8=0 frame");

    // R13 mode 10 internal divider, fast
    div_fast = 1'b1;
    reg_write(1'b0, 8'h98);
    tx_send(8'h81, 1'b1, 1'b1, 32, "R13 fast divider frame");
    div_fast = 1'b0;

    // R6 receive mode 01
    reg_write(1'b0, 8'h50);
    rx_frame(8'h3C, 1'b0, 1'b0, 1'b1, 64);
    chk(ri == 1'b1, "R6 ri set", ri, 1);
    reg_read(1'b1, v); chk(v == 8'h3C, "R6 data", v, 8'h3C);
    reg_read(1'b0, v); chk(v == 8'h55, "R6 ctrl rb8", v, 8'h55);

    // R7 framing flag
    reg_write(1'b0, 8'h50);
    rx_frame(8'h11, 1'b0, 1'b0, 1'b0, 64);
    fe_sel = 1'b1;
    reg_read(1'b0, v); chk(v == 8'hD1, "R7 fe view", v, 8'hD1);
    fe_sel = 1'b0;
    reg_read(1'b0, v); chk(v == 8'h51, "R7 mode view", v, 8'h51);
    reg_write(1'b0, 8'h50);
    rx_frame(8'h22, 1'b0, 1'b0, 1'b1, 64);
    fe_sel = 1'b1;
    reg_read(1'b0, v); chk(v[7] == 1'b1, "R7 sticky", v[7], 1);
    reg_write(1'b0, 8'h50);
    reg_read(1'b0, v); chk(v[7] == 1'b0, "R7 sw clear", v[7], 0);
    reg_write(1'b0, 8'hD0);
    fe_sel = 1'b0;
    reg_read(1'b0, v); chk(v[7] == 1'b0, "R7 mode bit untouched", v[7], 0);
    fe_sel = 1'b1;
    reg_write(1'b0, 8'h50);
    fe_sel = 1'b0;

    // R8 receive disabled
    reg_write(1'b0, 8'h40);
    rx_frame(8'h77, 1'b0, 1'b0, 1'b1, 64);
    chk(ri == 1'b0, "R8 ri", ri, 0);
    reg_read(1'b1, v); chk(v == 8'h22, "R8 data kept", v, 8'h22);

    // R9 9-bit filter
    reg_write(1'b0, 8'hF0);
    rx_frame(8'h42, 1'b1, 1'b0, 1'b1, 64);
    chk(ri == 1'b0, "R9 ninth=0 dropped", ri, 0);
    rx_frame(8'h42, 1'b1, 1'b1, 1'b1, 64);
    chk(ri == 1'b1, "R9 own addr", ri, 1);
    reg_read(1'b1, v); chk(v == 8'h42, "R9 data own", v, 8'h42);
    reg_write(1'b0, 8'hF0);
    rx_frame(8'h13, 1'b1, 1'b1, 1'b1, 64);
    chk(ri == 1'b0, "R9 no match", ri, 0);
    reg_read(1'b1, v); chk(v == 8'h42, "R9 data kept", v, 8'h42);
    rx_frame(8'hFF, 1'b1, 1'b1, 1'b1, 64);
    chk(ri == 1'b1, "R9 broadcast", ri, 1);

    // R10 8-bit filter
    reg_write(1'b0, 8'h70);
    rx_frame(8'h42, 1'b0, 1'b0, 1'b1, 64);
    chk(ri == 1'b1, "R10 good stop", ri, 1);
    reg_write(1'b0, 8'h70);
    rx_frame(8'h42, 1'b0, 1'b0, 1'b0, 64);
    chk(ri == 1'b0, "R10 bad stop", ri, 0);
    fe_sel = 1'b1;
    reg_write(1'b0, 8'h70);
    fe_sel = 1'b0;

    // R11 masked match
    own_addr = 8'h40; own_mask = 8'hF0;
    rx_frame(8'h4A, 1'b0, 1'b0, 1'b1, 64);
    chk(ri == 1'b1, "R11 masked hit", ri, 1);
    reg_read(1'b1, v); chk(v == 8'h4A, "R11 data", v, 8'h4A);
    reg_write(1'b0, 8'h70);
    rx_frame(8'h5A, 1'b0, 1'b0, 1'b1, 64);
    chk(ri == 1'b0, "R11 masked miss", ri, 0);

    // R12 short low pulse
    reg_write(1'b0, 8'h50);
    @(negedge clk); rxd = 1'b0;
    repeat (16) @(negedge clk);
    rxd = 1'b1;
    repeat (200) @(negedge clk);
    chk(ri == 1'b0, "R12 glitch dropped", ri, 0);
    rx_frame(8'h96, 1'b0, 1'b0, 1'b1, 64);
    reg_read(1'b1, v); chk(v == 8'h96 && ri, "R12 next frame", v, 8'h96);

    // R14 hardware set against software clear
    reg_write(1'b0, 8'h50);
    seen = 1'b0;
    fork
      rx_frame(8'h5A, 1'b0, 1'b0, 1'b1, 64);
      begin
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 1'b0; bus_wdata = 8'h50;
        repeat (11 * 64) begin
          @(negedge clk);
          if (ri) seen = 1'b1;
        end
        bus_wr = 1'b0;
      end
    join
    chk(seen, "R14 ri set wins", seen, 1);
    reg_read(1'b1, v); chk(v == 8'h5A, "R14 data", v, 8'h5A);

    finish_up();
  end
endmodule